// File: doc/BRIEF.md
# Life-Cycle Transition Sequencer

This block is the control state machine that carries one device life-cycle transition request from start to finish. After reset it passes through a boot state into idle. A request then walks a fixed chain of steps: clock switch-over, a saturation check on the transition counter, a counter write, a legality check of the requested target against the current state, a token hash, an optional erase step, and a two-part token comparison. The chain ends with a commit of the new state. Every step that can fail leaves the chain at once for a terminal "finished" state and reports an error.

The external helpers are modelled only as handshakes: the block holds a level request to a helper until that helper returns a one-cycle done, sampled together with an error flag where the helper has one. Two redundant escalation inputs override everything. The state register uses a sparse 8-bit code and is checked against the full legal set every cycle. A state that matches no code drops into a fault state.

Top module: `lcs_seq_fsm`

## Requirements
- R1: While `rst_ni` is low, every output is 0. The first clock edge after reset always lands in idle, even with `req_i` high. With `req_i` held high, `clk_sw_req_o` is therefore 1 only after the second edge.
- R2: In idle with `scrap_i` high, the machine enters a terminal scrap state with `scrap_o`=1. Scrap wins over `req_i`, and later requests are ignored.
- R3: An accepted request holds `clk_sw_req_o` high until `clk_sw_done_i`. One counter-check cycle follows. If `cnt_i` is all ones there, the machine finishes with error. Otherwise `cnt_prog_req_o` rises with `cnt_next_o` = `cnt_i`+1 (wrapping at CNT_W bits; `cnt_next_o` is 0 outside that step).
- R4: The counter write holds `cnt_prog_req_o` until `cnt_prog_done_i`. With `cnt_prog_err_i` the machine finishes with error. Otherwise one legality cycle follows, which passes only if `tgt_lc_i` > `cur_lc_i` (unsigned) and finishes with error if not.
- R5: The hash step holds `hash_req_o` until `hash_done_i`. With `hash_err_i` the machine finishes with error. Otherwise `hash_digest_i` is captured at that edge.
- R6: The erase step raises `erase_req_o` and waits for `erase_done_i` only when `tgt_lc_i` equals parameter RMA_LC. For any other target it passes in one cycle with `erase_req_o` low. This step never fails.
- R7: The first token cycle compares the low TOK_W/2 bits of the captured digest with those of `tok_exp_i`. A mismatch finishes with error.
- R8: The second token cycle repeats while `tok_vld_i` is low. Once it is high, it compares the high TOK_W/2 bits, and a mismatch finishes with error.
- R9: The commit step holds `prog_req_o` until `prog_done_i`, then finishes, with the error equal to `prog_err_i` at that edge.
- R10: The finished state is terminal until reset: `done_o` stays 1, `err_o` keeps its value, and `req_i` has no effect.
- R11: `esc_a_i` or `esc_b_i` high at any clock edge moves the machine to the escalate state, from every state including idle, finished, scrap and fault. `esc_o`=1 there, every request output is 0, and the state holds until reset.
- R12: A state register value outside the legal code set moves the machine, at the next edge, to a terminal fault state with `fault_o`=1 (escalation still takes priority).
- R13: `busy_o` is 1 exactly in the states from clock switch-over through commit, and at most one helper request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transition request, sampled in idle |
| scrap_i | input | 1 | Scrap condition, sampled in idle |
| esc_a_i | input | 1 | Escalation input, first copy |
| esc_b_i | input | 1 | Escalation input, second copy |
| cur_lc_i | input | LC_W | Current life-cycle state |
| tgt_lc_i | input | LC_W | Requested target state |
| cnt_i | input | CNT_W | Current transition count |
| clk_sw_req_o | output | 1 | Clock switch-over request |
| clk_sw_done_i | input | 1 | Clock switch-over done |
| cnt_prog_req_o | output | 1 | Counter write request |
| cnt_next_o | output | CNT_W | Counter value to write |
| cnt_prog_done_i | input | 1 | Counter write done |
| cnt_prog_err_i | input | 1 | Counter write error |
| hash_req_o | output | 1 | Token hash request |
| hash_done_i | input | 1 | Token hash done |
| hash_err_i | input | 1 | Token hash error |
| hash_digest_i | input | TOK_W | Hashed token |
| erase_req_o | output | 1 | Erase request |
| erase_done_i | input | 1 | Erase done |
| tok_exp_i | input | TOK_W | Expected token |
| tok_vld_i | input | 1 | Expected token high half valid |
| prog_req_o | output | 1 | State commit request |
| prog_done_i | input | 1 | State commit done |
| prog_err_i | input | 1 | State commit error |
| busy_o | output | 1 | Transition in progress |
| done_o | output | 1 | Transition finished |
| err_o | output | 1 | Finished with error |
| scrap_o | output | 1 | Scrap state |
| esc_o | output | 1 | Escalate state |
| fault_o | output | 1 | Illegal encoding was seen |

## Verification
The bench builds the block with CNT_W=3, LC_W=4, TOK_W=16 and RMA_LC=9. A three-bit counter makes the saturated value 7 easy to drive. Matching the target against RMA_LC=9 selects the erase branch, and any other target selects the skip branch. The 16-bit token splits into two 8-bit halves, so the bench can miss on one half while the other matches. Illegal encodings cannot reach the state register through the ports, so the bench overwrites the register for one cycle to exercise the fault path.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int ST_W = 8;
  typedef logic [ST_W-1:0] lcs_state_t;

  // sparse codes; any other value is illegal
  localparam lcs_state_t ST_BOOT      = 8'h3C;
  localparam lcs_state_t ST_IDLE      = 8'hA5;
  localparam lcs_state_t ST_CLK_SW    = 8'h56;
  localparam lcs_state_t ST_CNT_BUMP  = 8'h9A;
  localparam lcs_state_t ST_CNT_WRITE = 8'h63;
  localparam lcs_state_t ST_LEGAL_CHK = 8'hC9;
  localparam lcs_state_t ST_TOK_HASH  = 8'h2E;
  localparam lcs_state_t ST_ERASE     = 8'hB1;
  localparam lcs_state_t ST_TOK_CMP_A = 8'h4D;
  localparam lcs_state_t ST_TOK_CMP_B = 8'hD2;
  localparam lcs_state_t ST_COMMIT    = 8'h78;
  localparam lcs_state_t ST_DONE      = 8'h87;
  localparam lcs_state_t ST_SCRAP     = 8'hE4;
  localparam lcs_state_t ST_ESCALATE  = 8'h1B;
  localparam lcs_state_t ST_BAD       = 8'hF0;

  function automatic logic lcs_is_legal(input lcs_state_t s);
    case (s)
      ST_BOOT, ST_IDLE, ST_CLK_SW, ST_CNT_BUMP, ST_CNT_WRITE,
      ST_LEGAL_CHK, ST_TOK_HASH, ST_ERASE, ST_TOK_CMP_A,
      ST_TOK_CMP_B, ST_COMMIT, ST_DONE, ST_SCRAP, ST_ESCALATE,
      ST_BAD:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lcs_state_reg.sv
module lcs_state_reg
  import lcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  lcs_state_t next_i,
  output lcs_state_t state_o,
  output logic       legal_o
);
  lcs_state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_BOOT;
    else         state_q <= next_i;
  end

  assign state_o = state_q;
  assign legal_o = lcs_is_legal(state_q);
endmodule

// File: rtl/lcs_next_state.sv
module lcs_next_state
  import lcs_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LC_W  = 4,
  parameter int TOK_W = 32
) (
  input  lcs_state_t       state_i,
  input  logic             legal_i,
  input  logic             esc_i,
  input  logic             scrap_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LC_W-1:0]  cur_lc_i,
  input  logic [LC_W-1:0]  tgt_lc_i,
  input  logic             need_erase_i,
  input  logic             clk_sw_done_i,
  input  logic             cnt_prog_done_i,
  input  logic             cnt_prog_err_i,
  input  logic             hash_done_i,
  input  logic             hash_err_i,
  input  logic             erase_done_i,
  input  logic [TOK_W-1:0] digest_i,
  input  logic [TOK_W-1:0] tok_exp_i,
  input  logic             tok_vld_i,
  input  logic             prog_done_i,
  input  logic             prog_err_i,
  output lcs_state_t       next_o,
  output logic             abort_o
);
  localparam int HALF = TOK_W / 2;

  logic lo_match, hi_match, cnt_sat;
  assign lo_match = digest_i[HALF-1:0] == tok_exp_i[HALF-1:0];
  assign hi_match = digest_i[TOK_W-1:HALF] == tok_exp_i[TOK_W-1:HALF];
  assign cnt_sat  = &cnt_i;

  always_comb begin
    next_o  = state_i;
    abort_o = 1'b0;
    if (esc_i) begin
      next_o = ST_ESCALATE;
    end else if (!legal_i) begin
      next_o = ST_BAD;
    end else begin
      case (state_i)
        ST_BOOT: next_o = ST_IDLE;
        ST_IDLE: begin
          if (scrap_i)    next_o = ST_SCRAP;
          else if (req_i) next_o = ST_CLK_SW;
        end
        ST_CLK_SW: if (clk_sw_done_i) next_o = ST_CNT_BUMP;
        ST_CNT_BUMP: begin
          if (cnt_sat) begin
            next_o  = ST_DONE;
            abort_o = 1'b1;
          end else begin
            next_o = ST_CNT_WRITE;
          end
        end
        ST_CNT_WRITE: begin
          if (cnt_prog_done_i) begin
            next_o  = cnt_prog_err_i ? ST_DONE : ST_LEGAL_CHK;
            abort_o = cnt_prog_err_i;
          end
        end
        ST_LEGAL_CHK: begin
          if (tgt_lc_i > cur_lc_i) begin
            next_o = ST_TOK_HASH;
          end else begin
            next_o  = ST_DONE;
            abort_o = 1'b1;
          end
        end
        ST_TOK_HASH: begin
          if (hash_done_i) begin
            next_o  = hash_err_i ? ST_DONE : ST_ERASE;
            abort_o = hash_err_i;
          end
        end
        ST_ERASE: if (!need_erase_i || erase_done_i) next_o = ST_TOK_CMP_A;
        ST_TOK_CMP_A: begin
          next_o  = lo_match ? ST_TOK_CMP_B : ST_DONE;
          abort_o = !lo_match;
        end
        ST_TOK_CMP_B: begin
          if (tok_vld_i) begin
            next_o  = hi_match ? ST_COMMIT : ST_DONE;
            abort_o = !hi_match;
          end
        end
        ST_COMMIT: begin
          if (prog_done_i) begin
            next_o  = ST_DONE;
            abort_o = prog_err_i;
          end
        end
        ST_DONE, ST_SCRAP, ST_ESCALATE, ST_BAD: next_o = state_i;
        default: next_o = ST_BAD;
      endcase
    end
  end
endmodule

// File: rtl/lcs_result_reg.sv
module lcs_result_reg
  import lcs_pkg::*;
#(
  parameter int TOK_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lcs_state_t       state_i,
  input  lcs_state_t       next_i,
  input  logic             abort_i,
  input  logic             hash_done_i,
  input  logic             hash_err_i,
  input  logic [TOK_W-1:0] hash_digest_i,
  output logic [TOK_W-1:0] digest_o,
  output logic             err_o
);
  logic [TOK_W-1:0] digest_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      digest_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (state_i == ST_TOK_HASH && hash_done_i && !hash_err_i)
        digest_q <= hash_digest_i;
      if (state_i != ST_DONE && next_i == ST_DONE)
        err_q <= abort_i;
    end
  end

  assign digest_o = digest_q;
  assign err_o    = err_q;
endmodule

// File: rtl/lcs_out_dec.sv
module lcs_out_dec
  import lcs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  lcs_state_t       state_i,
  input  logic             need_erase_i,
  input  logic             err_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clk_sw_req_o,
  output logic             cnt_prog_req_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             hash_req_o,
  output logic             erase_req_o,
  output logic             prog_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             scrap_o,
  output logic             esc_o,
  output logic             fault_o
);
  always_comb begin
    clk_sw_req_o   = 1'b0;
    cnt_prog_req_o = 1'b0;
    cnt_next_o     = '0;
    hash_req_o     = 1'b0;
    erase_req_o    = 1'b0;
    prog_req_o     = 1'b0;
    busy_o         = 1'b0;
    done_o         = 1'b0;
    err_o          = 1'b0;
    scrap_o        = 1'b0;
    esc_o          = 1'b0;
    fault_o        = 1'b0;
    case (state_i)
      ST_CLK_SW: begin
        clk_sw_req_o = 1'b1;
        busy_o       = 1'b1;
      end
      ST_CNT_BUMP, ST_LEGAL_CHK, ST_TOK_CMP_A, ST_TOK_CMP_B: busy_o = 1'b1;
      ST_CNT_WRITE: begin
        cnt_prog_req_o = 1'b1;
        cnt_next_o     = cnt_i + CNT_W'(1);
        busy_o         = 1'b1;
      end
      ST_TOK_HASH: begin
        hash_req_o = 1'b1;
        busy_o     = 1'b1;
      end
      ST_ERASE: begin
        erase_req_o = need_erase_i;
        busy_o      = 1'b1;
      end
      ST_COMMIT: begin
        prog_req_o = 1'b1;
        busy_o     = 1'b1;
      end
      ST_DONE: begin
        done_o = 1'b1;
        err_o  = err_i;
      end
      ST_SCRAP:    scrap_o = 1'b1;
      ST_ESCALATE: esc_o   = 1'b1;
      ST_BAD:      fault_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lcs_seq_fsm.sv
module lcs_seq_fsm
  import lcs_pkg::*;
#(
  parameter int          CNT_W  = 5,
  parameter int          LC_W   = 4,
  parameter int          TOK_W  = 32,
  parameter int unsigned RMA_LC = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             scrap_i,
  input  logic             esc_a_i,
  input  logic             esc_b_i,
  input  logic [LC_W-1:0]  cur_lc_i,
  input  logic [LC_W-1:0]  tgt_lc_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clk_sw_req_o,
  input  logic             clk_sw_done_i,
  output logic             cnt_prog_req_o,
  output logic [CNT_W-1:0] cnt_next_o,
  input  logic             cnt_prog_done_i,
  input  logic             cnt_prog_err_i,
  output logic             hash_req_o,
  input  logic             hash_done_i,
  input  logic             hash_err_i,
  input  logic [TOK_W-1:0] hash_digest_i,
  output logic             erase_req_o,
  input  logic             erase_done_i,
  input  logic [TOK_W-1:0] tok_exp_i,
  input  logic             tok_vld_i,
  output logic             prog_req_o,
  input  logic             prog_done_i,
  input  logic             prog_err_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             scrap_o,
  output logic             esc_o,
  output logic             fault_o
);
  lcs_state_t       state_q, state_d;
  logic             legal, abort, err_q, need_erase;
  logic [TOK_W-1:0] digest_q;

  assign need_erase = tgt_lc_i == LC_W'(RMA_LC);

  lcs_state_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .next_i  (state_d),
    .state_o (state_q),
    .legal_o (legal)
  );

  lcs_next_state #(.CNT_W(CNT_W), .LC_W(LC_W), .TOK_W(TOK_W)) u_next (
    .state_i         (state_q),
    .legal_i         (legal),
    .esc_i           (esc_a_i | esc_b_i),
    .scrap_i         (scrap_i),
    .req_i           (req_i),
    .cnt_i           (cnt_i),
    .cur_lc_i        (cur_lc_i),
    .tgt_lc_i        (tgt_lc_i),
    .need_erase_i    (need_erase),
    .clk_sw_done_i   (clk_sw_done_i),
    .cnt_prog_done_i (cnt_prog_done_i),
    .cnt_prog_err_i  (cnt_prog_err_i),
    .hash_done_i     (hash_done_i),
    .hash_err_i      (hash_err_i),
    .erase_done_i    (erase_done_i),
    .digest_i        (digest_q),
    .tok_exp_i       (tok_exp_i),
    .tok_vld_i       (tok_vld_i),
    .prog_done_i     (prog_done_i),
    .prog_err_i      (prog_err_i),
    .next_o          (state_d),
    .abort_o         (abort)
  );

  lcs_result_reg #(.TOK_W(TOK_W)) u_res (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state_q),
    .next_i        (state_d),
    .abort_i       (abort),
    .hash_done_i   (hash_done_i),
    .hash_err_i    (hash_err_i),
    .hash_digest_i (hash_digest_i),
    .digest_o      (digest_q),
    .err_o         (err_q)
  );

  lcs_out_dec #(.CNT_W(CNT_W)) u_out (
    .state_i        (state_q),
    .need_erase_i   (need_erase),
    .err_i          (err_q),
    .cnt_i          (cnt_i),
    .clk_sw_req_o   (clk_sw_req_o),
    .cnt_prog_req_o (cnt_prog_req_o),
    .cnt_next_o     (cnt_next_o),
    .hash_req_o     (hash_req_o),
    .erase_req_o    (erase_req_o),
    .prog_req_o     (prog_req_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .scrap_o        (scrap_o),
    .esc_o          (esc_o),
    .fault_o        (fault_o)
  );
endmodule

// File: rtl/lcs_seq_chk.sv
module lcs_seq_chk
  import lcs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             esc_a_i,
  input logic             esc_b_i,
  input logic [CNT_W-1:0] cnt_i,
  input lcs_state_t       state_q,
  input logic             clk_sw_req_o,
  input logic             clk_sw_done_i,
  input logic             cnt_prog_req_o,
  input logic             hash_req_o,
  input logic             erase_req_o,
  input logic             prog_req_o,
  input logic             prog_done_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             scrap_o,
  input logic             esc_o,
  input logic             fault_o
);
  logic esc;
  assign esc = esc_a_i | esc_b_i;

  AST_ESC_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc |=> esc_o); // R11
  AST_ESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_o |=> esc_o && !busy_o); // R11
  AST_SCRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrap_o && !esc |=> scrap_o); // R2
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !esc |=> done_o && $stable(err_o)); // R10
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !esc |=> fault_o); // R12
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CNT_BUMP && (&cnt_i) && !esc |=> done_o && err_o); // R3
  AST_CLK_SW_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sw_req_o && !clk_sw_done_i && !esc |=> clk_sw_req_o); // R3
  AST_COMMIT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o && !prog_done_i && !esc |=> prog_req_o); // R9
  AST_BOOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BOOT && req_i && !esc |=> !clk_sw_req_o && !busy_o); // R1
  AST_REQ_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clk_sw_req_o, cnt_prog_req_o, hash_req_o, erase_req_o, prog_req_o})); // R13
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sw_req_o | cnt_prog_req_o | hash_req_o | erase_req_o | prog_req_o) |-> busy_o); // R13
endmodule

bind lcs_seq_fsm lcs_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .esc_a_i        (esc_a_i),
  .esc_b_i        (esc_b_i),
  .cnt_i          (cnt_i),
  .state_q        (state_q),
  .clk_sw_req_o   (clk_sw_req_o),
  .clk_sw_done_i  (clk_sw_done_i),
  .cnt_prog_req_o (cnt_prog_req_o),
  .hash_req_o     (hash_req_o),
  .erase_req_o    (erase_req_o),
  .prog_req_o     (prog_req_o),
  .prog_done_i    (prog_done_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .scrap_o        (scrap_o),
  .esc_o          (esc_o),
  .fault_o        (fault_o)
);

// File: tb/sim_lcs_seq_fsm.sv
`timescale 1ns/1ps
module sim_lcs_seq_fsm;
  localparam int CNT_W = 3;
  localparam int LC_W  = 4;
  localparam int TOK_W = 16;
  localparam int RMA   = 9;
  localparam logic [TOK_W-1:0] DIG = 16'hBEEF;

  // model stage numbers
  localparam int M_BOOT = 0, M_IDLE = 1, M_CLK = 2, M_CNTB = 3, M_CNTW = 4,
                 M_LEGAL = 5, M_HASH = 6, M_ERASE = 7, M_CMPA = 8, M_CMPB = 9,
                 M_COMMIT = 10, M_DONE = 11, M_SCRAP = 12, M_ESC = 13, M_BAD = 14;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, scrap_i = 0, esc_a_i = 0, esc_b_i = 0;
  logic [LC_W-1:0] cur_lc_i = 0, tgt_lc_i = 0;
  logic [CNT_W-1:0] cnt_i = 0;
  logic clk_sw_done_i = 0, cnt_prog_done_i = 0, cnt_prog_err_i = 0;
  logic hash_done_i = 0, hash_err_i = 0, erase_done_i = 0;
  logic [TOK_W-1:0] hash_digest_i = DIG, tok_exp_i = DIG;
  logic tok_vld_i = 0, prog_done_i = 0, prog_err_i = 0;
  logic clk_sw_req_o, cnt_prog_req_o, hash_req_o, erase_req_o, prog_req_o;
  logic [CNT_W-1:0] cnt_next_o;
  logic busy_o, done_o, err_o, scrap_o, esc_o, fault_o;

  int checks = 0, fails = 0, cycles = 0, lat = 1, wc = 0;
  int ms = M_BOOT;
  bit m_err = 0, inj = 0, saw_erase = 0;
  logic [TOK_W-1:0] m_dig = '0;

  always #2.5 clk_i = ~clk_i;

  lcs_seq_fsm #(.CNT_W(CNT_W), .LC_W(LC_W), .TOK_W(TOK_W), .RMA_LC(RMA)) u0 (.*);

  function automatic string tag_of(int s);
    case (s)
      M_BOOT, M_IDLE: return "R1";
      M_CLK, M_CNTB:  return "R3";
      M_CNTW, M_LEGAL: return "R4";
      M_HASH:   return "R5";
      M_ERASE:  return "R6";
      M_CMPA:   return "R7";
      M_CMPB:   return "R8";
      M_COMMIT: return "R9";
      M_DONE:   return "R10";
      M_SCRAP:  return "R2";
      M_ESC:    return "R11";
      default:  return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model, one step per edge
  task automatic model_step();
    int n = ms;
    bit ab = 0;
    if (esc_a_i || esc_b_i) n = M_ESC;
    else if (inj) n = M_BAD;
    else begin
      case (ms)
        M_BOOT: n = M_IDLE;
        M_IDLE: if (scrap_i) n = M_SCRAP; else if (req_i) n = M_CLK;
        M_CLK: if (clk_sw_done_i) n = M_CNTB;
        M_CNTB: if (int'(cnt_i) == (1 << CNT_W) - 1) begin n = M_DONE; ab = 1; end
                else n = M_CNTW;
        M_CNTW: if (cnt_prog_done_i) begin
                  if (cnt_prog_err_i) begin n = M_DONE; ab = 1; end else n = M_LEGAL;
                end
        M_LEGAL: if (int'(tgt_lc_i) > int'(cur_lc_i)) n = M_HASH;
                 else begin n = M_DONE; ab = 1; end
        M_HASH: if (hash_done_i) begin
                  if (hash_err_i) begin n = M_DONE; ab = 1; end
                  else begin n = M_ERASE; m_dig = hash_digest_i; end
                end
        M_ERASE: if (int'(tgt_lc_i) != RMA || erase_done_i) n = M_CMPA;
        M_CMPA: if (m_dig[7:0] == tok_exp_i[7:0]) n = M_CMPB;
                else begin n = M_DONE; ab = 1; end
        M_CMPB: if (tok_vld_i) begin
                  if (m_dig[15:8] == tok_exp_i[15:8]) n = M_COMMIT;
                  else begin n = M_DONE; ab = 1; end
                end
        M_COMMIT: if (prog_done_i) begin n = M_DONE; ab = prog_err_i; end
        default: ;
      endcase
    end
    inj = 0;
    if (n == M_DONE && ms != M_DONE) m_err = ab;
    ms = n;
  endtask

  task automatic compare();
    string t = tag_of(ms);
    logic [CNT_W-1:0] nx = (ms == M_CNTW) ? CNT_W'(cnt_i + 1) : '0;
    logic [15:0] act, exp;
    act = {clk_sw_req_o, cnt_prog_req_o, hash_req_o, erase_req_o, prog_req_o,
           done_o, err_o, scrap_o, esc_o, fault_o, 6'd0};
    exp = {ms == M_CLK, ms == M_CNTW, ms == M_HASH,
           ms == M_ERASE && int'(tgt_lc_i) == RMA, ms == M_COMMIT,
           ms == M_DONE, ms == M_DONE && m_err, ms == M_SCRAP, ms == M_ESC,
           ms == M_BAD, 6'd0};
    chk(t, act, exp);
    chk("R3", cnt_next_o, nx);
    chk("R13", busy_o, (ms >= M_CLK && ms <= M_COMMIT));
    if (erase_req_o) saw_erase = 1;
  endtask

  always @(posedge clk_i) begin
    if (rst_ni) begin
      model_step();
      #1 compare();
    end
  end

  // helper responder: done one cycle after lat waits
  always @(negedge clk_i) begin
    if (clk_sw_done_i | cnt_prog_done_i | hash_done_i | erase_done_i | prog_done_i) begin
      clk_sw_done_i = 0; cnt_prog_done_i = 0; hash_done_i = 0;
      erase_done_i = 0; prog_done_i = 0; wc = 0;
    end else if (rst_ni && (clk_sw_req_o | cnt_prog_req_o | hash_req_o | erase_req_o | prog_req_o)) begin
      if (wc >= lat) begin
        clk_sw_done_i   = clk_sw_req_o;
        cnt_prog_done_i = cnt_prog_req_o;
        hash_done_i     = hash_req_o;
        erase_done_i    = erase_req_o;
        prog_done_i     = prog_req_o;
      end else wc++;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic do_reset(bit req_hold);
    @(negedge clk_i);
    rst_ni = 0; ms = M_BOOT; m_err = 0; inj = 0; saw_erase = 0;
    req_i = req_hold; scrap_i = 0; esc_a_i = 0; esc_b_i = 0; tok_vld_i = 1;
    cnt_prog_err_i = 0; hash_err_i = 0; prog_err_i = 0;
    tok_exp_i = DIG; cnt_i = 3'd2; cur_lc_i = 4'd3; tgt_lc_i = 4'd5; lat = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic wait_term();
    for (int i = 0; i < 200; i++) begin
      if (ms >= M_DONE) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
  endtask

  task automatic go();
    @(negedge clk_i); req_i = 1;
    @(negedge clk_i); req_i = 0;
  endtask

  initial begin
    // R1: reset state and first edge lands in idle
    do_reset(1);
    chk("R1", {busy_o, done_o, clk_sw_req_o, esc_o, fault_o}, 5'b0);
    @(negedge clk_i);
    chk("R1", clk_sw_req_o, 1'b0);
    @(negedge clk_i);
    chk("R1", clk_sw_req_o, 1'b1);
    req_i = 0;
    tgt_lc_i = 4'(RMA);
    tok_vld_i = 0;
    lat = 2;
    for (int i = 0; i < 100 && ms != M_CMPB; i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk("R8", busy_o, 1'b1);  // still waiting in second token cycle
    tok_vld_i = 1;
    wait_term();
    chk("R9", {done_o, err_o}, 2'b10);
    chk("R6", saw_erase, 1'b1);
    go();
    repeat (2) @(negedge clk_i);
    chk("R10", {done_o, busy_o}, 2'b10);

    // R6: skip erase for other targets
    do_reset(0); go(); wait_term();
    chk("R6", {saw_erase, done_o, err_o}, 3'b010);

    // R2: scrap wins over request
    do_reset(0);
    @(negedge clk_i); scrap_i = 1; req_i = 1;
    @(negedge clk_i); scrap_i = 0; req_i = 0;
    go(); @(negedge clk_i);
    chk("R2", {scrap_o, busy_o}, 2'b10);

    // R3: saturated counter
    do_reset(0); cnt_i = 3'd7; go(); wait_term();
    chk("R3", {done_o, err_o}, 2'b11);

    // R4: counter write error, then illegal target
    do_reset(0); cnt_prog_err_i = 1; go(); wait_term();
    chk("R4", {done_o, err_o}, 2'b11);
    do_reset(0); tgt_lc_i = 4'd3; go(); wait_term();
    chk("R4", {done_o, err_o}, 2'b11);

    // R5: hash error
    do_reset(0); hash_err_i = 1; go(); wait_term();
    chk("R5", {done_o, err_o}, 2'b11);

    // R7 / R8: token half mismatches
    do_reset(0); tok_exp_i = 16'hBE00; go(); wait_term();
    chk("R7", {done_o, err_o}, 2'b11);
    do_reset(0); tok_exp_i = 16'h00EF; go(); wait_term();
    chk("R8", {done_o, err_o}, 2'b11);

    // R9: commit error
    do_reset(0); prog_err_i = 1; lat = 4; go(); wait_term();
    chk("R9", {done_o, err_o}, 2'b11);

    // R11: escalation mid-hash via second input, then from idle and finished
    do_reset(0); lat = 5; go();
    for (int i = 0; i < 100 && ms != M_HASH; i++) @(negedge clk_i);
    esc_b_i = 1; @(negedge clk_i); esc_b_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R11", {esc_o, busy_o, hash_req_o}, 3'b100);
    do_reset(0); @(negedge clk_i);
    esc_a_i = 1; @(negedge clk_i); esc_a_i = 0; @(negedge clk_i);
    chk("R11", esc_o, 1'b1);
    do_reset(0); go(); wait_term();
    esc_a_i = 1; @(negedge clk_i); esc_a_i = 0; @(negedge clk_i);
    chk("R11", {esc_o, done_o}, 2'b10);

    // R12: illegal encoding injected into the state register
    do_reset(0); repeat (2) @(negedge clk_i);
    force u0.u_reg.state_q = 8'h00;
    #1 release u0.u_reg.state_q;
    inj = 1;
    @(negedge clk_i);
    chk("R12", fault_o, 1'b1);
    go(); @(negedge clk_i);
    chk("R12", {fault_o, busy_o}, 2'b10);
    esc_b_i = 1; @(negedge clk_i); esc_b_i = 0; @(negedge clk_i);
    chk("R11", {esc_o, fault_o}, 2'b10);

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule